// File: doc/BRIEF.md
# External Interrupt Edge-Detect Controller

This block gathers four asynchronous interrupt lines: a non-maskable line, two general request lines and one event-counter request line. Each line is brought into the clock domain through a synchronizer, and the block compares it with its value one clock earlier to find a rising or falling edge.

The non-maskable line sets a pending bit that holds until the processor acknowledges it. The global mask does not affect it. Each maskable line latches a flag. The flags pass through per-source enables and a global mask, and a fixed-priority encoder then produces one combined request and the index of the winning source. The event-counter line can take its input from a pin or from an internal PWM signal. It can trigger on rising, falling or both edges.

Software uses a small register port to set up edge selection, enables, pin-function selects and the global mask. The same port reads the flags and clears them.

Top module: `ext_irq_ctrl`

## Requirements
- R1: Each input line passes through a two-flop synchronizer and then an edge comparator. A level change driven before clock edge k sets the matching flag or pending bit at edge k+2, and not at any earlier edge.
- R2: Bit 0 of the config register (address 0) selects the non-maskable edge: 1 = rising, 0 = falling. Only the selected edge sets `nmi_req_o`.
- R3: `nmi_req_o` stays high until `nmi_ack_i` is sampled high, and the acknowledge then clears it.
- R4: Config bits 1 and 2 select the edge for general lines 0 and 1: 1 = rising, 0 = falling. The opposite edge leaves the flag unchanged.
- R5: A general line sets its flag (flag register, address 2, bit 0 or 1) only when its pin-function bit is 1. The pin-function bits are control register (address 1) bits 3 and 4.
- R6: The enable bits are control bits 0, 1 and 2, for general 0, general 1 and the event line. A cleared enable on a general line keeps its set flag from raising `irq_req_o`. The flag itself is still recorded.
- R7: Control bit 7 is the global mask. When it is 1, `irq_req_o` is low whatever flags are set, while `nmi_req_o` and the flags are unaffected.
- R8: Config bit 5 selects the event-line input: 0 = the `evt_pin_i` pin, 1 = `evt_pwm_i`. The unselected input has no effect on flag bit 2.
- R9: Config bits 4:3 hold the event-line edge code: 00 = falling, 01 = rising, 10 or 11 = both edges.
- R10: The event flag (flag bit 2) is set only while the event enable (control bit 2) is 1.
- R11: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An edge that arrives in the same cycle as a clear leaves the flag set.
- R12: Among the enabled, unmasked flags, priority runs general 0, then general 1, then the event line. `irq_id_o` gives the winner as 0, 1 or 2, and `irq_req_o` marks it valid.
- R13: The config register reads back bits 5:0 and the control register reads back bits 7 and 4:0. Unused bits read 0, and all registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable interrupt line |
| gen_irq_i | input | 2 | General request lines |
| evt_pin_i | input | 1 | Event-counter request pin |
| evt_pwm_i | input | 1 | Internal PWM source for the event line |
| nmi_ack_i | input | 1 | Acknowledge that clears the non-maskable pending bit |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 config, 1 control, 2 flags) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| nmi_req_o | output | 1 | Non-maskable request pending |
| irq_req_o | output | 1 | Combined maskable request, also valid for `irq_id_o` |
| irq_id_o | output | 2 | Index of highest-priority pending source |

## Verification
An edge detector stuck in the wrong state shows up three clocks after a line toggles. The flag register either gains a bit it should not have or misses one it should have. A mis-decoded edge code or source select shows up the same way.

A wrong mask or enable path appears on `irq_req_o` in the cycle after the register write. A priority fault appears at once on `irq_id_o` when two flags are set together.

A flag that loses the race against a clear reads 0 one cycle after the clear write. A non-maskable pending bit that drops without an acknowledge is visible on `nmi_req_o` on the next edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  parameter int unsigned DATA_W   = 8;
  parameter int unsigned ADDR_W   = 2;
  parameter int unsigned NUM_GEN  = 2;
  parameter int unsigned NUM_MASK = NUM_GEN + 1;
  parameter int unsigned ID_W     = $clog2(NUM_MASK);
  parameter int unsigned SYNC_STG = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FLG = ADDR_W'(2);

  // config register layout
  localparam int unsigned CFG_NMI_BIT = 0;
  localparam int unsigned CFG_GEN_LSB = 1;
  localparam int unsigned CFG_EVT_LSB = CFG_GEN_LSB + NUM_GEN;
  localparam int unsigned CFG_SRC_BIT = CFG_EVT_LSB + 2;

  // control register layout
  localparam int unsigned CTL_EN_LSB  = 0;
  localparam int unsigned CTL_PFN_LSB = NUM_MASK;
  localparam int unsigned CTL_MSK_BIT = DATA_W - 1;

  localparam logic [DATA_W-1:0] CFG_WMASK = DATA_W'((1 << (CFG_SRC_BIT + 1)) - 1);
  localparam logic [DATA_W-1:0] CTL_WMASK =
    DATA_W'(((1 << (CTL_PFN_LSB + NUM_GEN)) - 1) | (1 << CTL_MSK_BIT));

  typedef enum logic [1:0] {
    EVT_FALL  = 2'b00,
    EVT_RISE  = 2'b01,
    EVT_BOTH  = 2'b10,
    EVT_BOTH2 = 2'b11
  } evt_edge_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= cur;
    end
  end

  assign edge_o = (rise_en_i & cur & ~prev_q) | (fall_en_i & ~cur & prev_q);
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N   = 3,
  parameter int unsigned IDW = $clog2(N)
) (
  input  logic [N-1:0]   req_i,
  output logic           valid_o,
  output logic [IDW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                nmi_i,
  input  logic [NUM_GEN-1:0]  gen_irq_i,
  input  logic                evt_pin_i,
  input  logic                evt_pwm_i,
  input  logic                nmi_ack_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic                nmi_req_o,
  output logic                irq_req_o,
  output logic [ID_W-1:0]     irq_id_o
);
  logic [DATA_W-1:0]   cfg_q, ctl_q;
  logic [NUM_MASK-1:0] flg_q, flg_set, flg_clr, pending;
  logic                gmask;
  logic                nmi_edge, nmi_q;
  logic                evt_raw, evt_edge;
  evt_edge_e           evt_code;

  // register port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADDR_CFG) cfg_q <= reg_wdata_i & CFG_WMASK;
      if (reg_addr_i == ADDR_CTL) ctl_q <= reg_wdata_i & CTL_WMASK;
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CFG: reg_rdata_o = cfg_q;
      ADDR_CTL: reg_rdata_o = ctl_q;
      ADDR_FLG: reg_rdata_o = {{(DATA_W-NUM_MASK){1'b0}}, flg_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign gmask = ctl_q[CTL_MSK_BIT];

  // non-maskable path
  irq_edge_det #(.STAGES(SYNC_STG)) u_nmi_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (nmi_i),
    .rise_en_i (cfg_q[CFG_NMI_BIT]),
    .fall_en_i (~cfg_q[CFG_NMI_BIT]),
    .edge_o    (nmi_edge)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          nmi_q <= 1'b0;
    else if (nmi_edge)    nmi_q <= 1'b1;
    else if (nmi_ack_i)   nmi_q <= 1'b0;
  end
  assign nmi_req_o = nmi_q;

  // general request paths
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic gen_edge;
    irq_edge_det #(.STAGES(SYNC_STG)) u_det (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .d_i       (gen_irq_i[g]),
      .rise_en_i (cfg_q[CFG_GEN_LSB+g]),
      .fall_en_i (~cfg_q[CFG_GEN_LSB+g]),
      .edge_o    (gen_edge)
    );
    assign flg_set[g] = gen_edge & ctl_q[CTL_PFN_LSB+g];
  end

  // event-counter path
  assign evt_code = evt_edge_e'(cfg_q[CFG_EVT_LSB +: 2]);
  assign evt_raw  = cfg_q[CFG_SRC_BIT] ? evt_pwm_i : evt_pin_i;

  irq_edge_det #(.STAGES(SYNC_STG)) u_evt_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .d_i       (evt_raw),
    .rise_en_i (evt_code != EVT_FALL),
    .fall_en_i (evt_code != EVT_RISE),
    .edge_o    (evt_edge)
  );
  assign flg_set[NUM_GEN] = evt_edge & ctl_q[CTL_EN_LSB+NUM_GEN];

  // flags
  for (genvar f = 0; f < NUM_MASK; f++) begin : g_flg
    assign flg_clr[f] = reg_we_i && (reg_addr_i == ADDR_FLG) && !reg_wdata_i[f];
    irq_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (flg_set[f]),
      .clr_i  (flg_clr[f]),
      .q_o    (flg_q[f])
    );
  end

  assign pending = flg_q & ctl_q[CTL_EN_LSB +: NUM_MASK];

  irq_prio_enc #(.N(NUM_MASK), .IDW(ID_W)) u_prio (
    .req_i   (pending & {NUM_MASK{~gmask}}),
    .valid_o (irq_req_o),
    .idx_o   (irq_id_o)
  );
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                nmi_req_o,
  input logic                nmi_ack_i,
  input logic                irq_req_o,
  input logic [ID_W-1:0]     irq_id_o,
  input logic                gmask,
  input logic                evt_en,
  input logic [NUM_MASK-1:0] flg_q,
  input logic [NUM_MASK-1:0] flg_set,
  input logic [NUM_MASK-1:0] flg_clr,
  input logic [NUM_MASK-1:0] pending
);
  // R3
  nmi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_req_o && !nmi_ack_i |=> nmi_req_o);

  // R7
  gmask_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gmask |-> !irq_req_o);

  // R12
  prio_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending[0] && !gmask |-> irq_req_o && (irq_id_o == '0));

  // R12
  id_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_id_o < ID_W'(NUM_MASK)));

  // R10
  evt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_en && !flg_q[NUM_MASK-1] |=> !flg_q[NUM_MASK-1]);

  // R11
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_clr[0] && !flg_set[0] |=> !flg_q[0]);

  // R11
  flag_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flg_clr[0] && flg_set[0] |=> flg_q[0]);
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nmi_req_o (nmi_req_o),
  .nmi_ack_i (nmi_ack_i),
  .irq_req_o (irq_req_o),
  .irq_id_o  (irq_id_o),
  .gmask     (gmask),
  .evt_en    (ctl_q[ext_irq_pkg::CTL_EN_LSB+ext_irq_pkg::NUM_GEN]),
  .flg_q     (flg_q),
  .flg_set   (flg_set),
  .flg_clr   (flg_clr),
  .pending   (pending)
);

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nmi = 1'b0;
  logic [1:0] gen = 2'b00;
  logic       epin = 1'b0;
  logic       epwm = 1'b0;
  logic       ack = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       nmi_req, irq_req;
  logic [1:0] irq_id;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .nmi_i       (nmi),
    .gen_irq_i   (gen),
    .evt_pin_i   (epin),
    .evt_pwm_i   (epwm),
    .nmi_ack_i   (ack),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .nmi_req_o   (nmi_req),
    .irq_req_o   (irq_req),
    .irq_id_o    (irq_id)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flags(input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(2'd2, v);
    chk(v, exp, tag);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd0, v); chk(v, 8'h00, "R13 cfg reset");
    rd(2'd1, v); chk(v, 8'h00, "R13 ctl reset");
    rd(2'd2, v); chk(v, 8'h00, "R13 flags reset");
    chk({7'd0, nmi_req}, 8'd0, "R3 nmi reset");
    chk({7'd0, irq_req}, 8'd0, "R12 irq reset");
  endtask

  task automatic t_nmi();
    wr(2'd0, 8'h01);
    nmi = 1'b1;
    cyc(2); chk({7'd0, nmi_req}, 8'd0, "R1 nmi not before third edge");
    cyc(1); chk({7'd0, nmi_req}, 8'd1, "R1 R2 nmi rising");
    wr(2'd1, 8'h80);
    chk({7'd0, nmi_req}, 8'd1, "R7 nmi ignores mask");
    nmi = 1'b0;
    cyc(4); chk({7'd0, nmi_req}, 8'd1, "R3 nmi held");
    pulse_ack();
    chk({7'd0, nmi_req}, 8'd0, "R3 nmi ack clears");
    wr(2'd0, 8'h00);
    nmi = 1'b1;
    cyc(4); chk({7'd0, nmi_req}, 8'd0, "R2 rising ignored in falling mode");
    nmi = 1'b0;
    cyc(4); chk({7'd0, nmi_req}, 8'd1, "R2 nmi falling");
    pulse_ack();
    wr(2'd1, 8'h00);
  endtask

  task automatic t_gen();
    wr(2'd1, 8'h1B);
    wr(2'd0, 8'h02);
    gen[0] = 1'b1; cyc(4);
    chk_flags(8'h01, "R4 gen0 rising");
    chk({7'd0, irq_req}, 8'd1, "R12 req valid");
    chk({6'd0, irq_id}, 8'd0, "R12 id gen0");
    gen[1] = 1'b1; cyc(4);
    chk_flags(8'h01, "R4 gen1 rising ignored");
    gen[1] = 1'b0; cyc(4);
    chk_flags(8'h03, "R4 gen1 falling");
    chk({6'd0, irq_id}, 8'd0, "R12 gen0 over gen1");
    wr(2'd2, 8'h06);
    chk_flags(8'h02, "R11 write one keeps, zero clears");
    chk({6'd0, irq_id}, 8'd1, "R12 id gen1");
    wr(2'd2, 8'h00);
    chk_flags(8'h00, "R11 clear all");
    gen[0] = 1'b0; cyc(4);
    chk_flags(8'h00, "R4 gen0 falling ignored");
  endtask

  task automatic t_pinfn();
    wr(2'd1, 8'h13);
    gen[0] = 1'b1; cyc(4);
    chk_flags(8'h00, "R5 pin function off");
    gen[0] = 1'b0; cyc(4);
  endtask

  task automatic t_enable();
    wr(2'd1, 8'h18);
    gen[0] = 1'b1; cyc(4);
    chk_flags(8'h01, "R6 flag recorded while disabled");
    chk({7'd0, irq_req}, 8'd0, "R6 disabled no request");
    wr(2'd1, 8'h19);
    chk({7'd0, irq_req}, 8'd1, "R6 enable raises request");
    wr(2'd1, 8'h99);
    chk({7'd0, irq_req}, 8'd0, "R7 mask blocks");
    chk_flags(8'h01, "R7 flag kept under mask");
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    gen[0] = 1'b0; cyc(4);
  endtask

  task automatic t_evt();
    wr(2'd1, 8'h04);
    wr(2'd0, 8'h08);
    epwm = 1'b1; cyc(4);
    chk_flags(8'h00, "R8 pwm ignored with pin source");
    epwm = 1'b0; cyc(4);
    epin = 1'b1; cyc(4);
    chk_flags(8'h04, "R8 R9 pin rising");
    chk({6'd0, irq_id}, 8'd2, "R12 id event");
    wr(2'd2, 8'h00);
    epin = 1'b0; cyc(4);
    chk_flags(8'h00, "R9 falling ignored in rising mode");
    wr(2'd0, 8'h18);
    epin = 1'b1; cyc(4);
    chk_flags(8'h04, "R9 code 11 rising");
    wr(2'd2, 8'h00);
    epin = 1'b0; cyc(4);
    chk_flags(8'h04, "R9 code 11 falling");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h10);
    epin = 1'b1; cyc(4);
    chk_flags(8'h04, "R9 code 10 rising");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h00);
    epin = 1'b0; cyc(4);
    chk_flags(8'h04, "R9 code 00 falling");
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h28);
    epwm = 1'b1; cyc(4);
    chk_flags(8'h04, "R8 pwm source rising");
    wr(2'd2, 8'h00);
    epin = 1'b1; cyc(4);
    chk_flags(8'h00, "R8 pin ignored with pwm source");
    wr(2'd1, 8'h00);
    epwm = 1'b0; cyc(4);
    epwm = 1'b1; cyc(4);
    chk_flags(8'h00, "R10 event disabled no flag");
    epwm = 1'b0; cyc(4);
  endtask

  task automatic t_clr_race();
    wr(2'd0, 8'h18);
    cyc(4);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h04);
    epin = 1'b0; cyc(4);
    chk_flags(8'h04, "R11 setup flag");
    epin = 1'b1;
    cyc(2);
    we = 1'b1; addr = 2'd2; wdata = 8'h00;
    @(negedge clk);
    we = 1'b0;
    chk_flags(8'h04, "R11 edge wins over clear");
    wr(2'd2, 8'h00);
    chk_flags(8'h00, "R11 plain clear");
    wr(2'd1, 8'h00);
  endtask

  task automatic t_readback();
    logic [7:0] v;
    wr(2'd0, 8'hFF); rd(2'd0, v); chk(v, 8'h3F, "R13 cfg readback");
    wr(2'd1, 8'hFF); rd(2'd1, v); chk(v, 8'h9F, "R13 ctl readback");
    rd(2'd3, v); chk(v, 8'h00, "R13 unused address");
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_nmi();
    t_gen();
    t_pinfn();
    t_enable();
    t_evt();
    t_clr_race();
    t_readback();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule